// File: doc/BRIEF.md
# Banked Sample FIFO with Serial Readout

This block keeps the four newest sample words from a sensor data path. They sit in four slots that form two banks of two slots each. Slot 1 always holds the oldest sample written since the last completed read, and the later samples follow in arrival order. A host selects a bank with a 4-bit register address and pulses a start strobe. It then clocks the bank out one bit per shift-enable pulse: the bank's first slot before its second, and each slot MSB first. A data-valid strobe marks every bit presented.

The bank contents are captured when the read starts. Writes that arrive during a readout therefore never change the bits in flight. When a readout of the second bank finishes, that counts as a read. It empties the FIFO and clears the overrun flag, so new samples fill from slot 1 again. If more than four samples arrive between reads, the oldest one is dropped, the rest move toward slot 1, and a sticky overrun flag is raised.

Top module: `bank_fifo_serial`

## Requirements
- R1: A synchronous active-high reset empties all four slots and clears busy, overrun and ser_valid. A bank read after reset returns all zero bits.
- R2: Samples written since the last completed read fill slots 1 to 4 in arrival order. Slot 1 holds the oldest of them, and slots not yet written read as zero.
- R3: When idle, a start pulse with address 4'b0000 reads slots 1 and 2, and address 4'b0010 reads slots 3 and 4. The lower-numbered slot is sent first, each slot MSB first, for 2×W bits in all. ser_out holds its value while shift_en is low.
- R4: A start at any other address (for example 4'b0001 or 4'b0011) shifts out 2×W zero bits. It leaves slot contents, order and overrun unchanged.
- R5: A start pulse while idle raises busy on the next cycle. ser_valid is high exactly in the cycles where busy and shift_en are both high. busy falls after the 2×W-th valid bit.
- R6: Finishing a 4'b0010 readout empties every slot and clears overrun. Finishing a 4'b0000 or unused-address readout changes neither.
- R7: A write to a full FIFO drops slot 1, moves slots 2 to 4 down by one and puts the new sample in slot 4. It also sets overrun, which stays set until a 4'b0010 readout completes.
- R8: When a write arrives in the same cycle that a 4'b0010 readout completes, the read is applied first and the new sample becomes slot 1 of the fresh ordering.
- R9: A start pulse during a readout is ignored. Writes during a readout do not change the bits being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | W | Sample word |
| rd_start | input | 1 | Starts a bank readout when idle |
| rd_addr | input | 4 | Register address, sampled with rd_start |
| shift_en | input | 1 | Advances the readout by one bit |
| ser_out | output | 1 | Serial data bit |
| ser_valid | output | 1 | ser_out carries a bit this cycle |
| busy | output | 1 | A readout is in progress |
| overrun | output | 1 | Sticky flag: a sample was dropped |

## Verification
The bench drives a write on the very cycle a second-bank readout ends. A design that resolved this write-first would lose the new sample or leave stale data in slot 1. It also overfills the FIFO, where a circular-pointer mistake would send the wrong oldest sample first or drop the overrun flag early. Unused-address reads are followed by a real bank read, to catch a decode that wrongly clears or reorders the slots. Reads started in the middle of a readout, writes landing during a shift, and long gaps in shift_en check that the captured word is neither reloaded nor corrupted.

// File: rtl/bank_fifo_serial.sv
module bank_fifo_serial #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_start,
  input  logic [3:0]   rd_addr,
  input  logic         shift_en,
  output logic         ser_out,
  output logic         ser_valid,
  output logic         busy,
  output logic         overrun
);
  localparam int SW = 2 * W;
  localparam int CW = $clog2(SW);

  logic [W-1:0]  slot [4];
  logic [2:0]    fill;
  logic [SW-1:0] sh;
  logic [SW-1:0] snap;
  logic [CW-1:0] nbits;
  logic          busy_q, hi_bank, ovr_q;
  logic          last, done;

  assign last      = busy_q & shift_en & (nbits == CW'(SW - 1));
  assign done      = last & hi_bank;
  assign ser_out   = busy_q & sh[SW-1];
  assign ser_valid = busy_q & shift_en;
  assign busy      = busy_q;
  assign overrun   = ovr_q;

  always_comb begin
    case (rd_addr)
      4'b0000: snap = {slot[0], slot[1]};
      4'b0010: snap = {slot[2], slot[3]};
      default: snap = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      hi_bank <= 1'b0;
      sh      <= '0;
      nbits   <= '0;
    end else if (busy_q) begin
      if (shift_en) begin
        sh    <= sh << 1;
        nbits <= nbits + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end else if (rd_start) begin
      sh      <= snap;
      nbits   <= '0;
      busy_q  <= 1'b1;
      hi_bank <= (rd_addr == 4'b0010);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) slot[k] <= '0;
      fill  <= '0;
      ovr_q <= 1'b0;
    end else if (done) begin
      for (int k = 0; k < 4; k++) slot[k] <= '0;
      fill  <= '0;
      ovr_q <= 1'b0;
      if (wr_en) begin
        slot[0] <= wr_data;
        fill    <= 3'd1;
      end
    end else if (wr_en) begin
      if (fill == 3'd4) begin
        slot[0] <= slot[1];
        slot[1] <= slot[2];
        slot[2] <= slot[3];
        slot[3] <= wr_data;
        ovr_q   <= 1'b1;
      end else begin
        slot[fill[1:0]] <= wr_data;
        fill            <= fill + 3'd1;
      end
    end
  end
endmodule

// File: rtl/bank_fifo_serial_chk.sv
module bank_fifo_serial_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_start,
  input logic [3:0] rd_addr,
  input logic       shift_en,
  input logic       ser_out,
  input logic       ser_valid,
  input logic       busy,
  input logic       overrun
);
  logic zero_rd;

  always_ff @(posedge clk) begin
    if (rst) zero_rd <= 1'b0;
    else if (!busy && rd_start) zero_rd <= (rd_addr != 4'b0000) && (rd_addr != 4'b0010);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !busy && !overrun); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) !busy && rd_start |=> busy); // R5
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst) busy && !shift_en |=> busy); // R9
  AST_BIT_STABLE: assert property (@(posedge clk) disable iff (rst) busy && !shift_en |=> $stable(ser_out)); // R3
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst) busy && zero_rd |-> !ser_out); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) overrun && !ser_valid |=> overrun); // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(overrun) |-> $past(wr_en)); // R7
endmodule

bind bank_fifo_serial bank_fifo_serial_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_start(rd_start), .rd_addr(rd_addr),
  .shift_en(shift_en), .ser_out(ser_out), .ser_valid(ser_valid), .busy(busy),
  .overrun(overrun)
);

// File: tb/bank_fifo_serial_test.sv
`timescale 1ns/1ps
module bank_fifo_serial_test;
  localparam int W  = 8;
  localparam int SW = 2 * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_start = 1'b0;
  logic [3:0]   rd_addr = '0;
  logic         shift_en = 1'b0;
  logic         ser_out, ser_valid, busy, overrun;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  bank_fifo_serial #(.W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_start(rd_start),
    .rd_addr(rd_addr), .shift_en(shift_en), .ser_out(ser_out), .ser_valid(ser_valid),
    .busy(busy), .overrun(overrun)
  );

  logic [W-1:0] q_m[$];
  bit           bits_m[$];
  bit           busy_m = 1'b0, ovr_m = 1'b0, hi_m = 1'b0;

  always @(posedge clk) begin
    bit comp;
    comp = 1'b0;
    if (rst) begin
      q_m.delete(); bits_m.delete();
      busy_m = 1'b0; ovr_m = 1'b0;
    end else begin
      if (busy_m) begin
        if (shift_en) begin
          comp = (bits_m.size() == 1) && hi_m;
          void'(bits_m.pop_front());
          if (bits_m.size() == 0) busy_m = 1'b0;
        end
      end else if (rd_start) begin
        int base;
        base = (rd_addr == 4'b0000) ? 0 : (rd_addr == 4'b0010) ? 2 : -1;
        for (int j = 0; j < 2; j++) begin
          logic [W-1:0] v;
          v = (base >= 0 && base + j < q_m.size()) ? q_m[base + j] : '0;
          for (int b = W - 1; b >= 0; b--) bits_m.push_back(v[b]);
        end
        busy_m = 1'b1;
        hi_m   = (rd_addr == 4'b0010);
      end
      if (comp) begin
        q_m.delete();
        ovr_m = 1'b0;
      end
      if (wr_en) begin
        q_m.push_back(wr_data);
        if (q_m.size() > 4) begin
          void'(q_m.pop_front());
          ovr_m = 1'b1;
        end
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!done_flag) begin
      check("R5 busy", 64'(busy), 64'(busy_m));
      check("R5 ser_valid", 64'(ser_valid), 64'(busy_m && shift_en));
      check("R7 overrun", 64'(overrun), 64'(ovr_m));
      if (busy_m) check("R3 ser_out", 64'(ser_out), 64'(bits_m[0]));
    end
  end

  task automatic wr(input logic [W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input int wr_at, input logic [W-1:0] wv,
                    input int start_at, output logic [SW-1:0] got);
    got = '0;
    @(negedge clk); rd_start = 1'b1; rd_addr = a;
    for (int i = 0; i < SW; i++) begin
      @(negedge clk);
      rd_start = (i == start_at);
      if (i == start_at) rd_addr = 4'b0010;
      wr_en = (i == wr_at); wr_data = wv;
      shift_en = 1'b1;
      #1 got = {got[SW-2:0], ser_out};
    end
    @(negedge clk); shift_en = 1'b0; wr_en = 1'b0; rd_start = 1'b0;
  endtask

  initial begin
    logic [SW-1:0] g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 busy after reset", 64'(busy), 0);
    check("R1 overrun after reset", 64'(overrun), 0);
    check("R1 ser_valid after reset", 64'(ser_valid), 0);
    rd(4'b0000, -1, 0, -1, g); check("R1 empty bank", 64'(g), 0);

    wr(8'hA1); wr(8'hB2);
    rd(4'b0000, -1, 0, -1, g); check("R2 two samples in order", 64'(g), 64'h A1B2);
    rd(4'b0010, -1, 0, -1, g); check("R2 unwritten slots zero", 64'(g), 0);
    rd(4'b0000, -1, 0, -1, g); check("R6 cleared after bank 2 read", 64'(g), 0);

    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    rd(4'b0001, -1, 0, -1, g); check("R4 addr 0001 zero", 64'(g), 0);
    rd(4'b0011, -1, 0, -1, g); check("R4 addr 0011 zero", 64'(g), 0);
    rd(4'b0110, -1, 0, -1, g); check("R4 addr 0110 zero", 64'(g), 0);
    rd(4'b0000, -1, 0, -1, g); check("R4 order kept after unused reads", 64'(g), 64'h1122);
    rd(4'b0000, -1, 0, -1, g); check("R6 bank 1 read does not clear", 64'(g), 64'h1122);
    rd(4'b0010, -1, 0, -1, g); check("R3 bank 2 order", 64'(g), 64'h3344);

    wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04); wr(8'h05);
    #1 check("R7 overrun set", 64'(overrun), 1);
    rd(4'b0000, -1, 0, -1, g); check("R7 oldest dropped", 64'(g), 64'h0203);
    check("R7 overrun sticky", 64'(overrun), 1);
    rd(4'b0010, -1, 0, -1, g); check("R7 newest in slot 4", 64'(g), 64'h0405);
    check("R6 overrun cleared", 64'(overrun), 0);

    wr(8'h10); wr(8'h20);
    rd(4'b0010, SW - 1, 8'h77, -1, g);
    rd(4'b0000, -1, 0, -1, g); check("R8 write on completion becomes slot 1", 64'(g), 64'h7700);

    rd(4'b0010, -1, 0, -1, g);
    wr(8'hAA); wr(8'hBB);
    rd(4'b0000, 3, 8'hCC, 5, g); check("R9 snapshot and ignored restart", 64'(g), 64'hAABB);
    #1 check("R9 idle after one readout", 64'(busy), 0);
    rd(4'b0000, -1, 0, -1, g); check("R9 no clear from ignored restart", 64'(g), 64'hAABB);
    rd(4'b0010, -1, 0, -1, g); check("R9 write during shift stored", 64'(g), 64'hCC00);

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      wr_en    = ($urandom % 3) == 0;
      wr_data  = W'($urandom);
      shift_en = ($urandom % 4) != 0;
      rd_start = ($urandom % 5) == 0;
      case ($urandom % 5)
        0: rd_addr = 4'b0000;
        1: rd_addr = 4'b0001;
        2: rd_addr = 4'b0010;
        3: rd_addr = 4'b0011;
        default: rd_addr = 4'b0110;
      endcase
    end
    @(negedge clk); wr_en = 1'b0; rd_start = 1'b0; shift_en = 1'b0;
    repeat (2) @(negedge clk);
    #5;
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule